// File: doc/BRIEF.md
# SDRAM Self-Refresh Control Sequencer

This block combines one 32-bit control and status word with a small sequencer that moves an SDRAM device into and out of self-refresh and reloads its mode registers. Software writes the word to raise or drop a self-refresh request, to choose how many auto-refresh commands are issued on either side of self-refresh, and to ask for a mode-register reload. The sequencer then issues the commands, one at a time, on a command port with a valid/ready handshake.

A refresh burst is either a single auto-refresh or one per row, with the row count set by the `ROWS` parameter. The burst before entry and the burst after exit are selected independently. A status bit reports that the device is in self-refresh. The reload bit clears itself once the mode-register-set command has been taken. The open-bank limit field is stored in the word and driven out for the rest of the memory controller.

Top module: `sdram_sref_ctl`

## Requirements
- R1: After reset the word reads 0x0000_1088, `open_bank_limit` is 1 (two banks) and `cmd_valid` is low.
- R2: Bits 16:12 are read/write. `open_bank_limit` follows the written value from the cycle after the write. A value n allows n+1 open banks.
- R3: Writes leave the read-only positions unchanged. Bits 31:17 and 10 read 0, bits 8:6 read 010, and bit 11 is not writable. Bits 3, 2 and 0 are plain storage.
- R4: Bit 4 sets the number of auto-refresh commands (code 1) accepted before the self-refresh entry command (code 2). With bit 4 at 0 it is exactly one; with bit 4 at 1 it is exactly `ROWS`.
- R5: Bit 5 sets the number of auto-refresh commands accepted after the self-refresh exit command (code 3). With bit 5 at 0 it is exactly one; with bit 5 at 1 it is exactly `ROWS`.
- R6: Bit 11 reads 1 from the cycle after the entry command is accepted until the exit command is accepted. From the cycle after that it reads 0, and it reads 0 at all other times.
- R7: Writing 1 to bit 9 makes it read 1 from the next cycle. Writing 0 to it has no effect. It reads 0 from the cycle after the mode-register-set command (code 4) is accepted.
- R8: A reload requested while in self-refresh issues no mode-register-set command until the exit command and the post-exit burst have been accepted.
- R9: If bit 1 is cleared during the pre-entry burst, the burst still completes, no entry command is issued, and the sequencer returns to idle.
- R10: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid` stays high and `cmd_code` stays unchanged on the next cycle.
- R11: Command codes are AREF=1, SREF_ENTER=2, SREF_EXIT=3 and MRS=4. `cmd_code` is 0 whenever `cmd_valid` is low.
- R12: When the sequencer is idle with both a reload pending and a self-refresh request set, the mode-register-set command is issued first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Whole-word write strobe |
| reg_wr_data | input | 32 | Write data |
| reg_rd_data | output | 32 | Current register image |
| cmd_valid | output | 1 | A command is presented |
| cmd_code | output | 3 | Command code (R11) |
| cmd_ready | input | 1 | The command is accepted in a cycle where it is high together with `cmd_valid` |
| open_bank_limit | output | BANK_W | Open-bank limit field |

## Verification
The checker asserts on every cycle the properties of the command handshake: a stalled command is held and the code is zero when idle. It also asserts that the fixed register bits never change, that the status bit tracks accepted entry and exit commands, that the reload bit clears after a mode-register-set command, and that no such command appears while in self-refresh. Only the bench scenarios can show the exact burst lengths for each count setting. The same holds for an entry cancelled mid-burst, the ordering of a held reload behind the post-exit burst, and idle priority. The bench's cycle-by-cycle reference model catches any difference in timing.

// File: rtl/sdram_sref_ctl_pkg.sv
package sdram_sref_ctl_pkg;

  localparam int unsigned REG_W = 32;

  // bit positions inside the control/status word
  localparam int unsigned POS_SPARE0   = 0;
  localparam int unsigned POS_REQ      = 1;
  localparam int unsigned POS_SPARE2   = 2;
  localparam int unsigned POS_SPARE3   = 3;
  localparam int unsigned POS_PRE_ALL  = 4;
  localparam int unsigned POS_POST_ALL = 5;
  localparam int unsigned POS_MODE     = 9;
  localparam int unsigned POS_STAT     = 11;
  localparam int unsigned POS_BANK     = 12;

  localparam logic [2:0]  FIXED_PATTERN = 3'b010;   // bits 8:6
  localparam logic [2:0]  SPARE_RESET   = 3'b100;   // bits {3,2,0}

  typedef enum logic [2:0] {
    CMD_NONE     = 3'd0,
    CMD_AREF     = 3'd1,
    CMD_SR_ENTER = 3'd2,
    CMD_SR_EXIT  = 3'd3,
    CMD_MRS      = 3'd4
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE_BURST,
    ST_ENTER,
    ST_IN_SR,
    ST_EXIT,
    ST_POST_BURST,
    ST_MODE_SET
  } seq_e;

  function automatic cmd_e cmd_of_state(seq_e s);
    case (s)
      ST_PRE_BURST,
      ST_POST_BURST: return CMD_AREF;
      ST_ENTER:      return CMD_SR_ENTER;
      ST_EXIT:       return CMD_SR_EXIT;
      ST_MODE_SET:   return CMD_MRS;
      default:       return CMD_NONE;
    endcase
  endfunction

endpackage

// File: rtl/sdram_sref_ctl_csr.sv
module sdram_sref_ctl_csr
  import sdram_sref_ctl_pkg::*;
#(
  parameter int unsigned BANK_W     = 5,
  parameter int unsigned BANK_RESET = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              stat_set,
  input  logic              stat_clr,
  input  logic              mode_done,
  output logic [REG_W-1:0]  rd_data,
  output logic              sref_req,
  output logic              pre_all,
  output logic              post_all,
  output logic              mode_pend,
  output logic [BANK_W-1:0] open_bank
);

  logic [BANK_W-1:0] bank_q;
  logic              req_q;
  logic              pre_q;
  logic              post_q;
  logic [2:0]        spare_q;
  logic              pend_q;
  logic              stat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q  <= BANK_W'(BANK_RESET);
      req_q   <= 1'b0;
      pre_q   <= 1'b0;
      post_q  <= 1'b0;
      spare_q <= SPARE_RESET;
    end else if (wr_en) begin
      bank_q  <= wr_data[POS_BANK +: BANK_W];
      req_q   <= wr_data[POS_REQ];
      pre_q   <= wr_data[POS_PRE_ALL];
      post_q  <= wr_data[POS_POST_ALL];
      spare_q <= {wr_data[POS_SPARE3], wr_data[POS_SPARE2], wr_data[POS_SPARE0]};
    end
  end

  // reload trigger: set by a written 1, cleared by the sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= (pend_q & ~mode_done) | (wr_en & wr_data[POS_MODE]);
    end
  end

  // self-refresh status, owned by the sequencer events only
  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= 1'b0;
    end else if (stat_set) begin
      stat_q <= 1'b1;
    end else if (stat_clr) begin
      stat_q <= 1'b0;
    end
  end

  always_comb begin
    rd_data                       = '0;
    rd_data[POS_BANK +: BANK_W]   = bank_q;
    rd_data[POS_STAT]             = stat_q;
    rd_data[POS_MODE]             = pend_q;
    rd_data[8:6]                  = FIXED_PATTERN;
    rd_data[POS_POST_ALL]         = post_q;
    rd_data[POS_PRE_ALL]          = pre_q;
    rd_data[POS_SPARE3]           = spare_q[2];
    rd_data[POS_SPARE2]           = spare_q[1];
    rd_data[POS_REQ]              = req_q;
    rd_data[POS_SPARE0]           = spare_q[0];
  end

  assign sref_req  = req_q;
  assign pre_all   = pre_q;
  assign post_all  = post_q;
  assign mode_pend = pend_q;
  assign open_bank = bank_q;

endmodule

// File: rtl/sdram_sref_ctl_rowctr.sv
module sdram_sref_ctl_rowctr #(
  parameter int unsigned ROWS = 8192
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic load_all,
  input  logic dec,
  output logic last
);

  localparam int unsigned CNT_W = $clog2(ROWS + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_all ? CNT_W'(ROWS) : CNT_W'(1);
    end else if (dec && cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign last = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/sdram_sref_ctl_seq.sv
module sdram_sref_ctl_seq
  import sdram_sref_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sref_req,
  input  logic       pre_all,
  input  logic       post_all,
  input  logic       mode_pend,
  input  logic       cmd_ready,
  input  logic       ctr_last,
  output logic       ctr_load,
  output logic       ctr_load_all,
  output logic       ctr_dec,
  output logic       stat_set,
  output logic       stat_clr,
  output logic       mode_done,
  output logic       cmd_valid,
  output logic [2:0] cmd_code
);

  seq_e state_q, state_n;
  logic valid_q;
  cmd_e code_q;
  logic accept;

  assign accept = valid_q & cmd_ready;

  always_comb begin
    state_n      = state_q;
    ctr_load     = 1'b0;
    ctr_load_all = 1'b0;
    ctr_dec      = 1'b0;
    stat_set     = 1'b0;
    stat_clr     = 1'b0;
    mode_done    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (mode_pend) begin
          state_n = ST_MODE_SET;
        end else if (sref_req) begin
          state_n      = ST_PRE_BURST;
          ctr_load     = 1'b1;
          ctr_load_all = pre_all;
        end
      end
      ST_PRE_BURST: begin
        if (accept) begin
          ctr_dec = 1'b1;
          if (ctr_last) begin
            state_n = sref_req ? ST_ENTER : ST_IDLE;
          end
        end
      end
      ST_ENTER: begin
        if (accept) begin
          state_n  = ST_IN_SR;
          stat_set = 1'b1;
        end
      end
      ST_IN_SR: begin
        if (!sref_req) begin
          state_n = ST_EXIT;
        end
      end
      ST_EXIT: begin
        if (accept) begin
          state_n      = ST_POST_BURST;
          stat_clr     = 1'b1;
          ctr_load     = 1'b1;
          ctr_load_all = post_all;
        end
      end
      ST_POST_BURST: begin
        if (accept) begin
          ctr_dec = 1'b1;
          if (ctr_last) begin
            state_n = ST_IDLE;
          end
        end
      end
      ST_MODE_SET: begin
        if (accept) begin
          state_n   = ST_IDLE;
          mode_done = 1'b1;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  // command outputs are registered from the next state
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      valid_q <= 1'b0;
      code_q  <= CMD_NONE;
    end else begin
      state_q <= state_n;
      valid_q <= (cmd_of_state(state_n) != CMD_NONE);
      code_q  <= cmd_of_state(state_n);
    end
  end

  assign cmd_valid = valid_q;
  assign cmd_code  = code_q;

endmodule

// File: rtl/sdram_sref_ctl.sv
module sdram_sref_ctl
  import sdram_sref_ctl_pkg::*;
#(
  parameter int unsigned ROWS       = 8192,
  parameter int unsigned BANK_W     = 5,
  parameter int unsigned BANK_RESET = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic [31:0]       reg_wr_data,
  output logic [31:0]       reg_rd_data,
  output logic              cmd_valid,
  output logic [2:0]        cmd_code,
  input  logic              cmd_ready,
  output logic [BANK_W-1:0] open_bank_limit
);

  logic sref_req, pre_all, post_all, mode_pend;
  logic stat_set, stat_clr, mode_done;
  logic ctr_load, ctr_load_all, ctr_dec, ctr_last;

  sdram_sref_ctl_csr #(
    .BANK_W     (BANK_W),
    .BANK_RESET (BANK_RESET)
  ) csr_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (reg_wr_en),
    .wr_data   (reg_wr_data),
    .stat_set  (stat_set),
    .stat_clr  (stat_clr),
    .mode_done (mode_done),
    .rd_data   (reg_rd_data),
    .sref_req  (sref_req),
    .pre_all   (pre_all),
    .post_all  (post_all),
    .mode_pend (mode_pend),
    .open_bank (open_bank_limit)
  );

  sdram_sref_ctl_rowctr #(
    .ROWS (ROWS)
  ) ctr_i (
    .clk      (clk),
    .rst      (rst),
    .load     (ctr_load),
    .load_all (ctr_load_all),
    .dec      (ctr_dec),
    .last     (ctr_last)
  );

  sdram_sref_ctl_seq seq_i (
    .clk          (clk),
    .rst          (rst),
    .sref_req     (sref_req),
    .pre_all      (pre_all),
    .post_all     (post_all),
    .mode_pend    (mode_pend),
    .cmd_ready    (cmd_ready),
    .ctr_last     (ctr_last),
    .ctr_load     (ctr_load),
    .ctr_load_all (ctr_load_all),
    .ctr_dec      (ctr_dec),
    .stat_set     (stat_set),
    .stat_clr     (stat_clr),
    .mode_done    (mode_done),
    .cmd_valid    (cmd_valid),
    .cmd_code     (cmd_code)
  );

endmodule

// File: rtl/sdram_sref_ctl_chk.sv
module sdram_sref_ctl_chk (
  input logic        clk,
  input logic        rst,
  input logic        reg_wr_en,
  input logic [31:0] reg_wr_data,
  input logic [31:0] reg_rd_data,
  input logic        cmd_valid,
  input logic [2:0]  cmd_code,
  input logic        cmd_ready
);

  p_hold_cmd_r10: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_code)));

  p_idle_code_r11: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |-> (cmd_code == 3'd0));

  p_fixed_bits_r3: assert property (@(posedge clk) disable iff (rst)
    (reg_rd_data[8:6] == 3'b010) && (reg_rd_data[31:17] == '0) && !reg_rd_data[10]);

  p_stat_rise_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && cmd_code == 3'd2) |=> reg_rd_data[11]);

  p_stat_fall_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && cmd_code == 3'd3) |=> !reg_rd_data[11]);

  p_mode_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && cmd_code == 3'd4 && !(reg_wr_en && reg_wr_data[9]))
      |=> !reg_rd_data[9]);

  p_no_mrs_in_sr_r8: assert property (@(posedge clk) disable iff (rst)
    reg_rd_data[11] |-> !(cmd_valid && cmd_code == 3'd4));

endmodule

bind sdram_sref_ctl sdram_sref_ctl_chk chk_i (
  .clk         (clk),
  .rst         (rst),
  .reg_wr_en   (reg_wr_en),
  .reg_wr_data (reg_wr_data),
  .reg_rd_data (reg_rd_data),
  .cmd_valid   (cmd_valid),
  .cmd_code    (cmd_code),
  .cmd_ready   (cmd_ready)
);

// File: tb/sdram_sref_ctl_tb_top.sv
`timescale 1ns/1ps
module sdram_sref_ctl_tb_top;

  localparam int ROWS = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0;
  logic [31:0] reg_wr_data = '0;
  logic [31:0] reg_rd_data;
  logic        cmd_valid;
  logic [2:0]  cmd_code;
  logic        cmd_ready = 1'b0;
  logic [4:0]  open_bank_limit;

  always #2 clk = ~clk;   // 250 MHz

  sdram_sref_ctl #(.ROWS(ROWS)) dut_i (
    .clk             (clk),
    .rst             (rst),
    .reg_wr_en       (reg_wr_en),
    .reg_wr_data     (reg_wr_data),
    .reg_rd_data     (reg_rd_data),
    .cmd_valid       (cmd_valid),
    .cmd_code        (cmd_code),
    .cmd_ready       (cmd_ready),
    .open_bank_limit (open_bank_limit)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h t=%0t", tag, act, exp, $time);
    end
  endtask

  // ready generator
  int cyc = 0;
  bit hold_ready = 1'b0;
  always @(posedge clk) begin
    #1;
    cyc++;
    cmd_ready = hold_ready ? 1'b0 : ((cyc % 5) != 2 && (cyc % 7) != 3);
  end

  // behavioural reference model: 0 idle,1 pre,2 enter,3 in,4 exit,5 post,6 mode
  int ms = 0, mcnt = 0;
  int m_bank = 1;
  bit m_req, m_pre, m_post, m_pend, m_stat;
  bit [2:0] m_spare = 3'b100;

  function automatic int exp_code(int s);
    case (s)
      1, 5: return 1;
      2: return 2;
      4: return 3;
      6: return 4;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] exp_rd();
    logic [31:0] r = '0;
    r[16:12] = m_bank[4:0];
    r[11] = m_stat; r[9] = m_pend; r[8:6] = 3'b010;
    r[5] = m_post; r[4] = m_pre; r[3] = m_spare[2]; r[2] = m_spare[1];
    r[1] = m_req; r[0] = m_spare[0];
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      ms = 0; mcnt = 0; m_bank = 1; m_req = 0; m_pre = 0; m_post = 0;
      m_pend = 0; m_stat = 0; m_spare = 3'b100;
    end else begin
      bit acc, done, sset, sclr;
      int nxt;
      acc = (exp_code(ms) != 0) && cmd_ready;
      done = 0; sset = 0; sclr = 0; nxt = ms;
      case (ms)
        0: if (m_pend) nxt = 6;
           else if (m_req) begin nxt = 1; mcnt = m_pre ? ROWS : 1; end
        1: if (acc) begin if (mcnt == 1) nxt = m_req ? 2 : 0; else mcnt--; end
        2: if (acc) begin nxt = 3; sset = 1; end
        3: if (!m_req) nxt = 4;
        4: if (acc) begin nxt = 5; sclr = 1; mcnt = m_post ? ROWS : 1; end
        5: if (acc) begin if (mcnt == 1) nxt = 0; else mcnt--; end
        6: if (acc) begin nxt = 0; done = 1; end
        default: nxt = 0;
      endcase
      ms = nxt;
      if (reg_wr_en) begin
        m_bank = int'(reg_wr_data[16:12]);
        m_req = reg_wr_data[1]; m_pre = reg_wr_data[4]; m_post = reg_wr_data[5];
        m_spare = {reg_wr_data[3], reg_wr_data[2], reg_wr_data[0]};
      end
      m_pend = (m_pend && !done) || (reg_wr_en && reg_wr_data[9]);
      if (sset) m_stat = 1; else if (sclr) m_stat = 0;
    end
  end

  // per-cycle comparison and event tracking
  int aref_cnt = 0, pre_seen = -1, enter_cnt = 0, mrs_cnt = 0;
  int mrs_arefs = -1, first_cmd = -1;
  bit mrs_in_sr = 0;

  always @(negedge clk) begin
    if (!rst) begin
      check(cmd_valid == (exp_code(ms) != 0), "R10 valid vs model", {31'd0, cmd_valid}, {31'd0, exp_code(ms) != 0});
      check(cmd_code == 3'(exp_code(ms)), "R11 code vs model", {29'd0, cmd_code}, exp_code(ms));
      check(reg_rd_data == exp_rd(), "R3 register image vs model", reg_rd_data, exp_rd());
      check(open_bank_limit == 5'(m_bank), "R2 bank limit vs model", {27'd0, open_bank_limit}, m_bank);
      if (cmd_valid && cmd_ready) begin
        if (first_cmd < 0) first_cmd = int'(cmd_code);
        case (cmd_code)
          3'd1: aref_cnt++;
          3'd2: begin pre_seen = aref_cnt; aref_cnt = 0; enter_cnt++; end
          3'd3: aref_cnt = 0;
          3'd4: begin mrs_cnt++; mrs_arefs = aref_cnt; mrs_in_sr = reg_rd_data[11]; end
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] word(bit req, bit pre, bit post, bit mode);
    return 32'h0000_1008 | (32'(post) << 5) | (32'(pre) << 4) | (32'(mode) << 9) | (32'(req) << 1);
  endfunction

  task automatic wr(input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr_en = 1'b1; reg_wr_data = d;
    @(posedge clk); #1;
    reg_wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (ms == 0 && !cmd_valid) break;
    end
    @(negedge clk);
  endtask

  task automatic wait_stat();
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (reg_rd_data[11]) break;
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(reg_rd_data == 32'h0000_1088, "R1 reset word", reg_rd_data, 32'h0000_1088);
    check(open_bank_limit == 5'd1, "R1 reset bank limit", {27'd0, open_bank_limit}, 1);
    check(!cmd_valid, "R1 no command after reset", {31'd0, cmd_valid}, 0);

    // R2 bank field
    wr(32'h0000_5088);
    @(negedge clk);
    check(open_bank_limit == 5'd5, "R2 bank limit written", {27'd0, open_bank_limit}, 5);

    // R3 read-only positions
    wr(32'hFFFF_FDFD);
    @(negedge clk);
    check(reg_rd_data == 32'h0001_F0BD, "R3 read-only bits kept", reg_rd_data, 32'h0001_F0BD);
    wr(32'h0000_1088);
    wait_idle();

    // R4 single pre refresh, R5 full post burst, R6 status
    aref_cnt = 0;
    wr(word(1, 0, 1, 0));
    wait_stat();
    check(pre_seen == 1, "R4 one refresh before entry", pre_seen, 1);
    check(reg_rd_data[11], "R6 status set in self-refresh", {31'd0, reg_rd_data[11]}, 1);
    wr(word(0, 0, 1, 0));
    wait_idle();
    check(aref_cnt == ROWS, "R5 all rows after exit", aref_cnt, ROWS);
    check(!reg_rd_data[11], "R6 status clear after exit", {31'd0, reg_rd_data[11]}, 0);

    // R4 full pre burst, R5 single post refresh
    aref_cnt = 0;
    wr(word(1, 1, 0, 0));
    wait_stat();
    check(pre_seen == ROWS, "R4 all rows before entry", pre_seen, ROWS);
    wr(word(0, 1, 0, 0));
    wait_idle();
    check(aref_cnt == 1, "R5 one refresh after exit", aref_cnt, 1);

    // R7 reload trigger, write of 0 ignored while pending
    hold_ready = 1'b1;
    wr(word(0, 0, 0, 1));
    @(negedge clk);
    check(reg_rd_data[9], "R7 reload pending", {31'd0, reg_rd_data[9]}, 1);
    wr(word(0, 0, 0, 0));
    @(negedge clk);
    check(reg_rd_data[9], "R7 write 0 does not cancel", {31'd0, reg_rd_data[9]}, 1);
    hold_ready = 1'b0;
    wait_idle();
    check(mrs_cnt == 1, "R7 one mode-set issued", mrs_cnt, 1);
    check(!reg_rd_data[9], "R7 trigger self-clears", {31'd0, reg_rd_data[9]}, 0);

    // R8 reload held during self-refresh
    wr(word(1, 0, 0, 0));
    wait_stat();
    wr(word(1, 0, 0, 1));
    repeat (20) @(negedge clk);
    check(mrs_cnt == 1, "R8 no mode-set while in self-refresh", mrs_cnt, 1);
    wr(word(0, 0, 0, 0));
    wait_idle();
    wait_idle();
    check(mrs_cnt == 2, "R8 mode-set after exit", mrs_cnt, 2);
    check(mrs_arefs == 1 && !mrs_in_sr, "R8 mode-set after post burst", mrs_arefs, 1);

    // R9 cancel during pre-entry burst
    aref_cnt = 0;
    wr(word(1, 1, 0, 0));
    for (int i = 0; i < 400 && aref_cnt < 3; i++) @(negedge clk);
    wr(word(0, 1, 0, 0));
    wait_idle();
    check(enter_cnt == 3, "R9 no entry after cancel", enter_cnt, 3);
    check(aref_cnt == ROWS, "R9 burst completes", aref_cnt, ROWS);

    // R12 reload before self-refresh when both pending in idle
    hold_ready = 1'b1;
    first_cmd = -1;
    wr(word(1, 0, 0, 1));
    repeat (3) @(negedge clk);
    hold_ready = 1'b0;
    wait_stat();
    check(first_cmd == 4, "R12 mode-set first", first_cmd, 4);
    wr(word(0, 0, 0, 0));
    wait_idle();

    finish_run();
  end

endmodule